// File: doc/BRIEF.md
# Shared Instruction Filter Cache

This block is a small set-associative store of individual instructions that sits in front of the instruction cache of a wide multithreaded front-end. Each warp's fetch probes it first. Many warps often run the same code close together in time, so an instruction that one warp brought in is likely to be wanted by another warp soon after. On a hit, the block returns the instruction itself, and the instruction cache's tag and data arrays are never touched.

On a miss, the fetch is passed to the instruction cache as a single request pulse. The block then waits for the response. The returned instruction is handed to the output and written into the least recently used way of its set. Only one miss may be in flight, and new fetches are held off until the fill finishes. A flush input invalidates the whole table in one cycle.

The default table has 32 entries of 64 bits each (256 bytes), arranged as 8 sets of 4 ways. A 16-entry table is chosen through the `ENTRIES` parameter.

Top module: `instr_filter_cache`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1, `out_valid` is 0 and `ic_req_valid` is 0, and every entry is invalid.
- R2: A fetch is accepted on a rising edge where `req_valid` and `req_ready` are both 1. If its PC matches a valid entry, the following conditions hold in the next cycle, whichever warp filled that entry. `out_valid` and `out_hit` are 1. `out_insn` is the stored instruction. `out_pc` and `out_warp` echo the request. `ic_req_valid` stays 0.
- R3: When an accepted fetch misses, `ic_req_valid` is 1 for exactly one cycle, the cycle after acceptance, with `ic_req_pc` equal to the fetch PC. `out_valid` stays 0 in that cycle.
- R4: An `ic_resp_valid` pulse arrives while a miss is waiting. In the next cycle, `out_valid` is 1 and `out_hit` is 0. `out_insn` equals `ic_resp_insn`, and `out_pc` and `out_warp` are those of the missing fetch. The instruction is kept, so a later fetch of that PC by any warp hits.
- R5: `req_ready` is 0 from the cycle after a miss is accepted until the fill has been output. A request presented while `req_ready` is 0 is ignored: it produces no output, no cache request and no fill.
- R6: Instructions are 8 bytes wide. The set index is PC bits [SET_W+2:3], which is PC[5:3] by default. The tag is the PC bits above the index. PCs that differ only in their tag share a set.
- R7: A fill goes to the lowest-numbered invalid way of its set. If every way is valid, it goes to the least recently used way. Each hit and each fill makes the way it touches the most recently used.
- R8: A flush invalidates every entry in the cycle after it is asserted. `req_ready` is 0 while flush is high. A fill that coincides with a flush is still output, but it is not kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Fetch may be accepted this cycle |
| req_pc | input | PC_W | Fetch address |
| req_warp | input | WARP_W | Requesting warp id |
| ic_req_valid | output | 1 | One-cycle request to the instruction cache |
| ic_req_pc | output | PC_W | Address sent to the instruction cache |
| ic_resp_valid | input | 1 | Instruction cache response strobe |
| ic_resp_insn | input | INSN_W | Instruction returned by the instruction cache |
| out_valid | output | 1 | Instruction output strobe |
| out_hit | output | 1 | Output was served from the table |
| out_insn | output | INSN_W | Delivered instruction |
| out_pc | output | PC_W | PC of the delivered instruction |
| out_warp | output | WARP_W | Warp of the delivered instruction |

## Verification
The assertions assume the following about the inputs. The instruction cache answers only while a miss is waiting, never in the same cycle as its request pulse, and with exactly one `ic_resp_valid` pulse per request. Under these conditions the table never holds the same tag twice in one set, and the LRU ages of every set always form a permutation.

The stimulus keeps within these limits. Every response is driven one full cycle after the request pulse has been observed, and one response is given per miss. During a wait, the bench drives a competing request to show that it is ignored. It also aligns a flush with a fill response.

// File: rtl/ifc_pkg.sv
// Package: shared types of the instruction filter cache.
// Assumes nothing beyond IEEE 1800-2017.
package ifc_pkg;
    // Miss-handling states: idle, request pulse, waiting for response
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } fill_state_e;
endpackage

// File: rtl/ifc_tag_store.sv
// Module: valid, tag and instruction arrays with a parallel way compare.
// Provides one lookup port, one valid-vector read port for victim choice
// and one write port. Flush clears all valid bits and wins over a write.
// Assumes the writer never installs a tag already present in the set.
module ifc_tag_store #(
    parameter int SETS   = 8,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 26,
    parameter int INSN_W = 64,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [SET_W-1:0]  lk_set,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [WAY_W-1:0]  lk_way,
    output logic [INSN_W-1:0] lk_insn,
    input  logic [SET_W-1:0]  vq_set,
    output logic [WAYS-1:0]   vq_valid,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [INSN_W-1:0] wr_insn
);
    logic [SETS-1:0][WAYS-1:0] valid_q;
    logic [TAG_W-1:0]          tag_q  [SETS][WAYS];
    logic [INSN_W-1:0]         insn_q [SETS][WAYS];
    logic [WAYS-1:0]           match;

    // Per-way tag comparison for the lookup set
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    end

    // Encode the matching way and select its instruction
    always_comb begin
        lk_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) lk_way = WAY_W'(w);
        end
    end

    assign lk_hit   = |match;
    assign lk_insn  = insn_q[lk_set][lk_way];
    assign vq_valid = valid_q[vq_set];

    // Valid bits: reset and flush clear, write sets
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= 1'b1;
        end
    end

    // Tag and instruction payload written on fill
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way]  <= wr_tag;
            insn_q[wr_set][wr_way] <= wr_insn;
        end
    end

    // R7
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));
endmodule

// File: rtl/ifc_lru.sv
// Module: true LRU ages per set. Each way holds an age; 0 is most recent
// and WAYS-1 is the oldest. A touch moves the way to age 0 and ages every
// younger way by one, so the ages of a set stay a permutation.
// Assumes at most one touch per cycle.
module ifc_lru #(
    parameter int SETS = 8,
    parameter int WAYS = 4,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] q_set,
    output logic [WAY_W-1:0] q_oldest
);
    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic [WAY_W-1:0] touched_age;

    assign touched_age = age_q[touch_set][touch_way];

    // Age update: touched way becomes youngest, younger ones shift older
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
            end
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    age_q[touch_set][w] <= '0;
                end else if (age_q[touch_set][w] < touched_age) begin
                    age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
                end
            end
        end
    end

    // Find the oldest way of the queried set
    always_comb begin
        q_oldest = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_q[q_set][w] == WAY_W'(WAYS - 1)) q_oldest = WAY_W'(w);
        end
    end

    for (genvar s = 0; s < SETS; s++) begin : g_set_chk
        logic [WAYS-1:0] oldest_vec;
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            assign oldest_vec[w] = (age_q[s][w] == WAY_W'(WAYS - 1));
        end
        // R7
        single_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot(oldest_vec));
    end
endmodule

// File: rtl/ifc_ctrl.sv
// Module: fetch acceptance, single outstanding miss and output register.
// A hit is delivered the cycle after acceptance; a miss raises a one-cycle
// cache request, waits for the response, then delivers and fills.
// Assumes the response never arrives in the request-pulse cycle.
module ifc_ctrl
    import ifc_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int WARP_W = 5,
    parameter int INSN_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              req_valid,
    input  logic [PC_W-1:0]   req_pc,
    input  logic [WARP_W-1:0] req_warp,
    output logic              req_ready,
    output logic              accept,
    input  logic              lk_hit,
    input  logic [INSN_W-1:0] lk_insn,
    output logic [PC_W-1:0]   pend_pc,
    output logic              ic_req_valid,
    input  logic              ic_resp_valid,
    input  logic [INSN_W-1:0] ic_resp_insn,
    output logic              fill_en,
    output logic              out_valid,
    output logic              out_hit,
    output logic [INSN_W-1:0] out_insn,
    output logic [PC_W-1:0]   out_pc,
    output logic [WARP_W-1:0] out_warp
);
    fill_state_e       state_q;
    logic [WARP_W-1:0] pend_warp;

    assign req_ready    = (state_q == ST_IDLE) && !flush;
    assign accept       = req_valid && req_ready;
    assign ic_req_valid = (state_q == ST_SEND);
    assign fill_en      = (state_q == ST_WAIT) && ic_resp_valid;

    // Miss state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept && !lk_hit) state_q <= ST_SEND;
                ST_SEND: state_q <= ST_WAIT;
                ST_WAIT: if (ic_resp_valid) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the missing fetch for request and fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_pc   <= '0;
            pend_warp <= '0;
        end else if (accept && !lk_hit) begin
            pend_pc   <= req_pc;
            pend_warp <= req_warp;
        end
    end

    // Output register for hits and fills
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_insn  <= '0;
            out_pc    <= '0;
            out_warp  <= '0;
        end else begin
            out_valid <= (accept && lk_hit) || fill_en;
            if (accept && lk_hit) begin
                out_hit  <= 1'b1;
                out_insn <= lk_insn;
                out_pc   <= req_pc;
                out_warp <= req_warp;
            end else if (fill_en) begin
                out_hit  <= 1'b0;
                out_insn <= ic_resp_insn;
                out_pc   <= pend_pc;
                out_warp <= pend_warp;
            end
        end
    end

    // R3
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ic_req_valid |=> !ic_req_valid);

    // R4
    fill_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (out_valid && !out_hit));

    // R5
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ic_req_valid |=> !req_ready);
endmodule

// File: rtl/instr_filter_cache.sv
// Module: shared instruction filter cache, top level.
// Splits the PC into offset, set and tag; looks the fetch up in the
// tag store; on a miss chooses a victim (invalid way first, else LRU)
// and fills it when the instruction cache answers.
// Assumes ENTRIES is a multiple of WAYS and instructions are 8 bytes.
module instr_filter_cache
    import ifc_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int WAYS    = 4,
    parameter int PC_W    = 32,
    parameter int WARP_W  = 5,
    parameter int INSN_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PC_W-1:0]   req_pc,
    input  logic [WARP_W-1:0] req_warp,
    output logic              ic_req_valid,
    output logic [PC_W-1:0]   ic_req_pc,
    input  logic              ic_resp_valid,
    input  logic [INSN_W-1:0] ic_resp_insn,
    output logic              out_valid,
    output logic              out_hit,
    output logic [INSN_W-1:0] out_insn,
    output logic [PC_W-1:0]   out_pc,
    output logic [WARP_W-1:0] out_warp
);
    localparam int SETS  = ENTRIES / WAYS;
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int OFF_W = $clog2(INSN_W / 8);
    localparam int TAG_W = PC_W - SET_W - OFF_W;

    logic              accept, lk_hit, fill_en;
    logic [WAY_W-1:0]  lk_way, lru_oldest, vic_way;
    logic [INSN_W-1:0] lk_insn;
    logic [PC_W-1:0]   pend_pc;
    logic [WAYS-1:0]   vq_valid;
    logic [SET_W-1:0]  req_set, pend_set;
    logic [TAG_W-1:0]  req_tag, pend_tag;

    assign req_set  = req_pc[OFF_W +: SET_W];
    assign req_tag  = req_pc[PC_W-1 -: TAG_W];
    assign pend_set = pend_pc[OFF_W +: SET_W];
    assign pend_tag = pend_pc[PC_W-1 -: TAG_W];
    assign ic_req_pc = pend_pc;

    // Victim choice: lowest invalid way, otherwise the oldest way
    always_comb begin
        vic_way = lru_oldest;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vq_valid[w]) vic_way = WAY_W'(w);
        end
    end

    ifc_ctrl #(.PC_W(PC_W), .WARP_W(WARP_W), .INSN_W(INSN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_pc(req_pc), .req_warp(req_warp),
        .req_ready(req_ready), .accept(accept),
        .lk_hit(lk_hit), .lk_insn(lk_insn), .pend_pc(pend_pc),
        .ic_req_valid(ic_req_valid), .ic_resp_valid(ic_resp_valid),
        .ic_resp_insn(ic_resp_insn), .fill_en(fill_en),
        .out_valid(out_valid), .out_hit(out_hit), .out_insn(out_insn),
        .out_pc(out_pc), .out_warp(out_warp)
    );

    ifc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .INSN_W(INSN_W)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_set(req_set), .lk_tag(req_tag), .lk_hit(lk_hit),
        .lk_way(lk_way), .lk_insn(lk_insn),
        .vq_set(pend_set), .vq_valid(vq_valid),
        .wr_en(fill_en), .wr_set(pend_set), .wr_way(vic_way),
        .wr_tag(pend_tag), .wr_insn(ic_resp_insn)
    );

    ifc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk(clk), .rst_n(rst_n),
        .touch_en((accept && lk_hit) || fill_en),
        .touch_set(fill_en ? pend_set : req_set),
        .touch_way(fill_en ? vic_way : lk_way),
        .q_set(pend_set), .q_oldest(lru_oldest)
    );

    // R2
    hit_no_icache_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lk_hit) |=> (out_valid && out_hit && !ic_req_valid));

    // R3
    miss_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !lk_hit) |=> (ic_req_valid && !out_valid));
endmodule

// File: tb/instr_filter_cache_bench.sv
module instr_filter_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_pc = '0;
    logic [4:0]  req_warp = '0;
    logic        ic_resp_valid = 1'b0;
    logic [63:0] ic_resp_insn = '0;
    logic        req_ready, ic_req_valid, out_valid, out_hit;
    logic [31:0] ic_req_pc, out_pc;
    logic [63:0] out_insn;
    logic [4:0]  out_warp;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    instr_filter_cache u_instr_filter_cache (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_pc(req_pc),
        .req_warp(req_warp), .ic_req_valid(ic_req_valid), .ic_req_pc(ic_req_pc),
        .ic_resp_valid(ic_resp_valid), .ic_resp_insn(ic_resp_insn),
        .out_valid(out_valid), .out_hit(out_hit), .out_insn(out_insn),
        .out_pc(out_pc), .out_warp(out_warp)
    );

    // Vector: {pc[31:0], warp[4:0], expect_hit}; set index is PC[5:3]
    localparam logic [37:0] VEC [16] = '{
        {32'h0000_1000, 5'd0, 1'b0},  // R3 cold miss
        {32'h0000_1000, 5'd1, 1'b1},  // R2 other warp hits
        {32'h0000_1008, 5'd2, 1'b0},  // R6 set 1
        {32'h0000_1008, 5'd3, 1'b1},
        {32'h0000_1040, 5'd4, 1'b0},  // R6 set 0, new tag
        {32'h0000_1080, 5'd5, 1'b0},
        {32'h0000_10C0, 5'd6, 1'b0},  // set 0 full
        {32'h0000_1000, 5'd7, 1'b1},  // touch A
        {32'h0000_1100, 5'd0, 1'b0},  // R7 evicts 1040
        {32'h0000_1040, 5'd1, 1'b0},  // R7 evicts 1080
        {32'h0000_1000, 5'd2, 1'b1},
        {32'h0000_10C0, 5'd3, 1'b1},
        {32'h0000_1100, 5'd4, 1'b1},
        {32'h0000_1080, 5'd5, 1'b0},  // R7 evicts 1040
        {32'h0000_1040, 5'd6, 1'b0},  // R7 evicts 1000
        {32'h0000_1000, 5'd7, 1'b0}
    };

    function automatic logic [63:0] mem_insn(input logic [31:0] pc);
        return {pc ^ 32'hA5A5_0000, ~pc};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one fetch and the instruction cache response if it misses
    task automatic fetch(input logic [31:0] pc, input logic [4:0] warp,
                         input logic exp_hit, input logic flush_on_fill);
        @(negedge clk);
        check("R5 ready before fetch", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_pc = pc; req_warp = warp;
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_hit) begin
            check("R2 hit valid", 64'(out_valid), 64'd1);
            check("R2 hit flag", 64'(out_hit), 64'd1);
            check("R2 hit insn", out_insn, mem_insn(pc));
            check("R2 hit warp", 64'(out_warp), 64'(warp));
            check("R2 no cache request", 64'(ic_req_valid), 64'd0);
        end else begin
            check("R3 request valid", 64'(ic_req_valid), 64'd1);
            check("R3 request pc", 64'(ic_req_pc), 64'(pc));
            check("R3 no output", 64'(out_valid), 64'd0);
            @(negedge clk);
            check("R3 request one cycle", 64'(ic_req_valid), 64'd0);
            check("R5 stalled", 64'(req_ready), 64'd0);
            ic_resp_valid = 1'b1; ic_resp_insn = mem_insn(pc);
            flush = flush_on_fill;
            @(negedge clk);
            ic_resp_valid = 1'b0; flush = 1'b0;
            check("R4 fill valid", 64'(out_valid), 64'd1);
            check("R4 fill flag", 64'(out_hit), 64'd0);
            check("R4 fill insn", out_insn, mem_insn(pc));
            check("R4 fill pc", 64'(out_pc), 64'(pc));
            check("R4 fill warp", 64'(out_warp), 64'(warp));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", 64'(req_ready), 64'd1);
        check("R1 out_valid", 64'(out_valid), 64'd0);
        check("R1 ic_req_valid", 64'(ic_req_valid), 64'd0);

        for (int i = 0; i < 16; i++) begin
            fetch(VEC[i][37:6], VEC[i][5:1], VEC[i][0], 1'b0);
        end

        // R5: request during a wait is ignored
        @(negedge clk);
        req_valid = 1'b1; req_pc = 32'h0000_3010; req_warp = 5'd9;
        @(negedge clk);
        req_valid = 1'b0;
        check("R5 miss pulse", 64'(ic_req_valid), 64'd1);
        @(negedge clk);
        req_valid = 1'b1; req_pc = 32'h0000_3018; req_warp = 5'd10;
        @(negedge clk);
        check("R5 ignored no request", 64'(ic_req_valid), 64'd0);
        check("R5 ignored no output", 64'(out_valid), 64'd0);
        ic_resp_valid = 1'b1; ic_resp_insn = mem_insn(32'h0000_3010);
        @(negedge clk);
        ic_resp_valid = 1'b0; req_valid = 1'b0;
        check("R5 original pc out", 64'(out_pc), 64'h3010);
        @(negedge clk);
        check("R5 ignored no late output", 64'(out_valid), 64'd0);
        check("R5 ignored no late request", 64'(ic_req_valid), 64'd0);
        fetch(32'h0000_3018, 5'd10, 1'b0, 1'b0);  // R5 never filled
        fetch(32'h0000_3010, 5'd11, 1'b1, 1'b0);  // R4 kept

        // R8 flush
        fetch(32'h0000_1008, 5'd1, 1'b1, 1'b0);
        @(negedge clk);
        flush = 1'b1;
        #1 check("R8 ready low in flush", 64'(req_ready), 64'd0);
        @(negedge clk);
        flush = 1'b0;
        fetch(32'h0000_1008, 5'd2, 1'b0, 1'b0);  // R8 invalidated
        fetch(32'h0000_2000, 5'd3, 1'b0, 1'b1);  // R8 flush with fill
        fetch(32'h0000_2000, 5'd4, 1'b0, 1'b0);  // R8 fill not kept
        fetch(32'h0000_2000, 5'd5, 1'b1, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule